// File: doc/BRIEF.md
# Floating-Point Coprocessor Control Register Unit

This unit holds the control and identification words of a floating-point coprocessor and serves the move-to and move-from transfers that reach them. Each transfer presents a 4-bit register selector, a direction flag, write data, the current privilege level, and a grant signal. The grant signal states whether the coprocessor may be used at all. The unit then either returns the selected word, commits the write, or flags the transfer as an undefined instruction.

Two registers can be written: a status/control word and an exception word. Bit 30 of the exception word is the coprocessor enable. The enable decides whether the status/control word can be reached. The identification word and the two feature words are constants. Writes to them are accepted without a fault and have no effect.

Top module: `fpu_sysreg_unit`

## Requirements
- R1: The selector codes are: 4'b0000 identification, 4'b0001 status/control, 4'b1000 exception, 4'b0111 feature word 0, 4'b0110 feature word 1. Any other code faults.
- R2: An allowed read returns 0x4102315 followed by the 4-bit `REV` parameter for the identification word. It returns 0x10110221 for feature word 0 and 0x00000011 for feature word 1.
- R3: After synchronous reset, the status/control and exception words read 0x00000000 and `fpEnable` is 0.
- R4: A privileged, granted write to the identification word or to either feature word raises no fault, and later reads of that word return the same constant.
- R5: The identification, feature and exception words are reachable only when `privMode` is 1, whatever the enable bit is. An unprivileged access to any of them faults.
- R6: The status/control word is reachable at either privilege level only while exception bit 30 is 1. While that bit is 0, every access to it faults, privileged or not.
- R7: Every access with `cpGrant` low faults.
- R8: A faulting access asserts `accFault` in the same cycle as `accValid`, drives `rdData` to zero and changes no register.
- R9: An allowed write to the exception word stores the whole word on the next rising edge. `fpEnable` then shows its bit 30, and from that edge on, permission checks use the new value.
- R10: When `accValid` is low, or when the access is a write, `rdData` is zero and `accFault` is low. An allowed write to the status/control word is read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| accValid | input | 1 | A transfer is presented this cycle |
| accWrite | input | 1 | 1 = move to register, 0 = move from register |
| accSel | input | 4 | Register selector |
| wrData | input | 32 | Data for a write transfer |
| privMode | input | 1 | 1 = privileged level |
| cpGrant | input | 1 | Coprocessor access granted |
| rdData | output | 32 | Read data, zero unless an allowed read |
| accFault | output | 1 | Undefined-instruction indication |
| fpEnable | output | 1 | Current enable bit (exception bit 30) |

## Verification
The hardest state to reach from the ports is an open status/control register. Reaching it takes an earlier transfer that is privileged, granted and aimed at the exception word, with bit 30 set in its data. The random stimulus therefore weights exception-word writes heavily and draws bit 30 separately, so that the enable toggles often. That lets status/control accesses be tried at both privilege levels with the enable open and with it closed. Directed cases cover the edge where the enable changes, ignored writes to constant words, unknown selectors, and a missing grant.

// File: rtl/fpu_sysreg_pkg.sv
package fpu_sysreg_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 4;

  localparam logic [SEL_W-1:0] SEL_ID    = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_STAT  = 4'b0001;
  localparam logic [SEL_W-1:0] SEL_EXC   = 4'b1000;
  localparam logic [SEL_W-1:0] SEL_FEAT0 = 4'b0111;
  localparam logic [SEL_W-1:0] SEL_FEAT1 = 4'b0110;

  localparam logic [WORD_W-1:0] FEAT0_VAL = 32'h1011_0221;
  localparam logic [WORD_W-1:0] FEAT1_VAL = 32'h0000_0011;
  localparam logic [WORD_W-5:0] ID_HIGH   = 28'h410_2315;

  typedef enum logic [2:0] {
    RK_NONE, RK_ID, RK_STAT, RK_EXC, RK_FEAT0, RK_FEAT1
  } regKind_e;

  typedef struct packed {
    logic     wrStat;
    logic     wrExc;
    logic     rdEn;
    regKind_e kind;
  } dpCtrl_t;

  function automatic regKind_e decodeSel(input logic [SEL_W-1:0] s);
    case (s)
      SEL_ID:    return RK_ID;
      SEL_STAT:  return RK_STAT;
      SEL_EXC:   return RK_EXC;
      SEL_FEAT0: return RK_FEAT0;
      SEL_FEAT1: return RK_FEAT1;
      default:   return RK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fpu_sysreg_ctrl.sv
module fpu_sysreg_ctrl
  import fpu_sysreg_pkg::*;
(
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [SEL_W-1:0] accSel,
  input  logic             privMode,
  input  logic             cpGrant,
  input  logic             enBit,
  output dpCtrl_t          dpCtrl,
  output logic             accFault
);
  regKind_e kind;
  logic     permit;
  logic     granted;

  always_comb begin
    kind = decodeSel(accSel);
    case (kind)
      RK_STAT:                          permit = enBit;
      RK_ID, RK_EXC, RK_FEAT0, RK_FEAT1: permit = privMode;
      default:                          permit = 1'b0;
    endcase
    granted = accValid && cpGrant && permit;

    dpCtrl.kind   = kind;
    dpCtrl.rdEn   = granted && !accWrite;
    dpCtrl.wrStat = granted && accWrite && (kind == RK_STAT);
    dpCtrl.wrExc  = granted && accWrite && (kind == RK_EXC);
    accFault      = accValid && !granted;
  end
endmodule

// File: rtl/fpu_sysreg_dp.sv
module fpu_sysreg_dp
  import fpu_sysreg_pkg::*;
#(
  parameter logic [3:0] REV    = 4'h0,
  parameter int         EN_BIT = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wrData,
  input  dpCtrl_t           dpCtrl,
  output logic [WORD_W-1:0] rdData,
  output logic              enBit
);
  localparam logic [WORD_W-1:0] ID_VAL = {ID_HIGH, REV};

  logic [WORD_W-1:0] statReg;
  logic [WORD_W-1:0] excReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      statReg <= '0;
      excReg  <= '0;
    end else begin
      if (dpCtrl.wrStat) statReg <= wrData;
      if (dpCtrl.wrExc)  excReg  <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (dpCtrl.rdEn) begin
      case (dpCtrl.kind)
        RK_ID:    rdData = ID_VAL;
        RK_STAT:  rdData = statReg;
        RK_EXC:   rdData = excReg;
        RK_FEAT0: rdData = FEAT0_VAL;
        RK_FEAT1: rdData = FEAT1_VAL;
        default:  rdData = '0;
      endcase
    end
  end

  assign enBit = excReg[EN_BIT];
endmodule

// File: rtl/fpu_sysreg_unit.sv
module fpu_sysreg_unit
  import fpu_sysreg_pkg::*;
#(
  parameter logic [3:0] REV    = 4'h0,
  parameter int         EN_BIT = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [3:0]  accSel,
  input  logic [31:0] wrData,
  input  logic        privMode,
  input  logic        cpGrant,
  output logic [31:0] rdData,
  output logic        accFault,
  output logic        fpEnable
);
  dpCtrl_t dpCtrl;
  logic    enBit;

  fpu_sysreg_ctrl u_ctrl (
    .accValid(accValid), .accWrite(accWrite), .accSel(accSel),
    .privMode(privMode), .cpGrant(cpGrant), .enBit(enBit),
    .dpCtrl(dpCtrl), .accFault(accFault)
  );

  fpu_sysreg_dp #(.REV(REV), .EN_BIT(EN_BIT)) u_dp (
    .clk(clk), .rst(rst), .wrData(wrData), .dpCtrl(dpCtrl),
    .rdData(rdData), .enBit(enBit)
  );

  assign fpEnable = enBit;
endmodule

// File: rtl/fpu_sysreg_checker.sv
module fpu_sysreg_checker
  import fpu_sysreg_pkg::*;
#(
  parameter int EN_BIT = 30
) (
  input logic        clk,
  input logic        rst,
  input logic        accValid,
  input logic        accWrite,
  input logic [3:0]  accSel,
  input logic [31:0] wrData,
  input logic        privMode,
  input logic        cpGrant,
  input logic [31:0] rdData,
  input logic        accFault,
  input logic        fpEnable
);
  logic hwOnly;
  assign hwOnly = (accSel == SEL_ID) || (accSel == SEL_EXC) ||
                  (accSel == SEL_FEAT0) || (accSel == SEL_FEAT1);

  p_reset_en_r3: assert property (@(posedge clk)
    $past(rst) |-> !fpEnable);

  p_unpriv_fault_r5: assert property (@(posedge clk) disable iff (rst)
    (accValid && !privMode && hwOnly) |-> accFault);

  p_stat_closed_r6: assert property (@(posedge clk) disable iff (rst)
    (accValid && accSel == SEL_STAT && !fpEnable) |-> accFault);

  p_no_grant_r7: assert property (@(posedge clk) disable iff (rst)
    (accValid && !cpGrant) |-> accFault);

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (rst)
    accFault |-> (rdData == '0));

  p_fault_keeps_en_r8: assert property (@(posedge clk) disable iff (rst)
    accFault |=> $stable(fpEnable));

  p_exc_write_r9: assert property (@(posedge clk) disable iff (rst)
    (accValid && accWrite && accSel == SEL_EXC && privMode && cpGrant)
      |=> (fpEnable == $past(wrData[EN_BIT])));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !accValid |-> (!accFault && rdData == '0));
endmodule

bind fpu_sysreg_unit fpu_sysreg_checker #(.EN_BIT(EN_BIT)) u_chk (
  .clk(clk), .rst(rst), .accValid(accValid), .accWrite(accWrite),
  .accSel(accSel), .wrData(wrData), .privMode(privMode), .cpGrant(cpGrant),
  .rdData(rdData), .accFault(accFault), .fpEnable(fpEnable)
);

// File: tb/fpu_sysreg_unit_bench.sv
module fpu_sysreg_unit_bench;
  localparam logic [3:0] TB_REV = 4'h3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accValid = 1'b0, accWrite = 1'b0, privMode = 1'b0, cpGrant = 1'b0;
  logic [3:0]  accSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        accFault, fpEnable;

  int nRun = 0, nFail = 0;
  logic [31:0] expStat = '0, expExc = '0;

  always #5 clk = ~clk;

  fpu_sysreg_unit #(.REV(TB_REV)) u_fpu_sysreg_unit (
    .clk(clk), .rst(rst), .accValid(accValid), .accWrite(accWrite),
    .accSel(accSel), .wrData(wrData), .privMode(privMode), .cpGrant(cpGrant),
    .rdData(rdData), .accFault(accFault), .fpEnable(fpEnable)
  );

  function automatic bit known(input logic [3:0] s);
    return s == 4'b0000 || s == 4'b0001 || s == 4'b1000 || s == 4'b0111 || s == 4'b0110;
  endfunction

  function automatic bit allowed(input logic [3:0] s, input bit pv, input bit gr, input bit en);
    if (!gr || !known(s)) return 0;
    if (s == 4'b0001) return en;
    return pv;
  endfunction

  function automatic logic [31:0] readVal(input logic [3:0] s);
    case (s)
      4'b0000: return {28'h410_2315, TB_REV};
      4'b0001: return expStat;
      4'b1000: return expExc;
      4'b0111: return 32'h1011_0221;
      4'b0110: return 32'h0000_0011;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic access(input bit v, input bit w, input logic [3:0] s,
                        input logic [31:0] d, input bit pv, input bit gr, input string tag);
    bit ok;
    @(negedge clk);
    accValid = v; accWrite = w; accSel = s; wrData = d; privMode = pv; cpGrant = gr;
    #1;
    ok = v && allowed(s, pv, gr, expExc[30]);
    check(tag, "accFault", {31'b0, accFault}, {31'b0, v && !ok});
    check(tag, "rdData", rdData, (ok && !w) ? readVal(s) : 32'h0);
    check(tag, "fpEnable", {31'b0, fpEnable}, {31'b0, expExc[30]});
    if (ok && w) begin
      if (s == 4'b0001) expStat = d;
      if (s == 4'b1000) expExc = d;
    end
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [3:0] s;
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    access(0, 0, 4'b0000, 0, 1, 1, "R3 reset/R10 idle");
    access(1, 0, 4'b1000, 0, 1, 1, "R3 exc reset");
    access(1, 0, 4'b0000, 0, 1, 1, "R2 id read R1");
    access(1, 0, 4'b0111, 0, 1, 1, "R2 feat0");
    access(1, 0, 4'b0110, 0, 1, 1, "R2 feat1");
    access(1, 0, 4'b0001, 0, 1, 1, "R6 stat closed priv");
    access(1, 0, 4'b0000, 0, 0, 1, "R5 unpriv id");
    access(1, 1, 4'b1000, 32'h4000_0000, 0, 1, "R5 unpriv exc write R8");
    access(1, 0, 4'b0111, 0, 0, 1, "R5 unpriv feat0");
    access(1, 1, 4'b0000, 32'hdead_beef, 1, 1, "R4 id write ignored");
    access(1, 1, 4'b0111, 32'hffff_ffff, 1, 1, "R4 feat0 write ignored");
    access(1, 0, 4'b0000, 0, 1, 1, "R4 id unchanged");
    access(1, 0, 4'b0111, 0, 1, 1, "R4 feat0 unchanged");
    access(1, 0, 4'b0011, 0, 1, 1, "R1 unknown sel");
    access(1, 0, 4'b1111, 0, 1, 1, "R1 unknown sel");
    access(1, 1, 4'b1000, 32'h4000_00aa, 1, 0, "R7 no grant R8");
    access(1, 1, 4'b1000, 32'h4000_00aa, 1, 1, "R9 enable write");
    access(1, 0, 4'b1000, 0, 1, 1, "R9 exc readback");
    access(1, 0, 4'b0001, 0, 0, 1, "R3 stat reset R6 unpriv open");
    access(1, 1, 4'b0001, 32'h0123_4567, 0, 1, "R10 stat write");
    access(1, 0, 4'b0001, 0, 1, 1, "R10 stat readback");
    access(1, 0, 4'b0001, 0, 1, 0, "R7 stat no grant");
    access(1, 1, 4'b1000, 32'h0000_0001, 1, 1, "R9 disable");
    access(1, 0, 4'b0001, 0, 1, 1, "R9 closed after write R6");
    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: s = 4'b1000;
        3, 4, 5: s = 4'b0001;
        6:       s = 4'b0000;
        7:       s = $urandom_range(0, 1) ? 4'b0111 : 4'b0110;
        default: s = 4'($urandom);
      endcase
      d = $urandom;
      d[30] = ($urandom_range(0, 2) != 0);
      access($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, s, d,
             $urandom_range(0, 3) != 0, $urandom_range(0, 7) != 0, "R8 random R9");
    end
    @(negedge clk); accValid = 0;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule